// File: doc/BRIEF.md
# Vector Binary32 Class Test

This block tests every binary32 lane of a 128-bit vector operand against a 12-bit class-select value. Each lane is sorted into one of six floating-point categories (zero, normal, subnormal, infinity, quiet NaN, signalling NaN), and each category is split by sign, which gives one bit per category in a 12-bit class vector. A lane passes when its class vector and the select value share at least one set bit.

The result is a lane mask, with all ones for a passing lane and all zeros for a failing one, plus a 2-bit condition code that tells whether all, some or none of the tested lanes passed. A single-lane control limits the test to lane 0 (bits 31:0). In that case the upper lanes of the mask read as zero, and the condition code only tells whether lane 0 passed.

The classification, matching and code generation are combinational. The results are captured in registers when the input strobe is high, so they appear one clock after the strobe and are held until the next strobe.

Top module: `vfp_class_test`

## Requirements
- R1: A lane's class vector has exactly one bit set. The bit positions are 11 for +zero, 10 for -zero, 9 for +normal, 8 for -normal, 7 for +subnormal, 6 for -subnormal, 5 for +infinity, 4 for -infinity, 3 for +quiet NaN, 2 for -quiet NaN, 1 for +signalling NaN and 0 for -signalling NaN. The sign is bit 31, the exponent is bits 30:23 and the mantissa is bits 22:0.
- R2: A lane passes when the AND of its class vector and `class_sel` is non-zero. A passing lane drives 32'hFFFFFFFF into its slice of `mask_out`, and a failing lane drives 32'h00000000.
- R3: An all-ones exponent with a non-zero mantissa is a NaN. It is quiet when mantissa bit 22 is 1 and signalling when that bit is 0.
- R4: `cc_out` is 0 when every tested lane passes.
- R5: `cc_out` is 1 when at least one tested lane passes and at least one fails.
- R6: `cc_out` is 3 when no tested lane passes, which includes the case `class_sel` = 0. The value 2 never appears.
- R7: When `single_lane` is 1, only lane 0 is tested. Lanes 1 to 3 of `mask_out` are zero, and `cc_out` is 0 if lane 0 passes and 3 otherwise.
- R8: `mask_out` and `cc_out` take the result of the inputs sampled at the clock edge where `in_valid` is 1. `out_valid` is 1 in the cycle after that edge and 0 otherwise.
- R9: While `in_valid` is 0, `mask_out` and `cc_out` hold their values whatever the other inputs do.
- R10: After reset, `out_valid` is 0, `mask_out` is zero and `cc_out` is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe: capture a new result |
| vec_in | input | 128 | Four binary32 lanes, lane 0 in bits 31:0 |
| class_sel | input | 12 | Class-select value (bit order as in R1) |
| single_lane | input | 1 | Test lane 0 only |
| out_valid | output | 1 | Result registered this cycle |
| mask_out | output | 128 | Per-lane all-ones / all-zeros mask |
| cc_out | output | 2 | Condition code: 0 all, 1 some, 3 none |

## Verification
Two functions can act on the same strobe and disagree. The single-lane restriction can cut off lanes that would otherwise pass, and the all/some/none condition code must then follow the restricted set. The bench provokes this with vectors where all four lanes pass but the single-lane control is set, and with vectors where only lanes 1 to 3 pass under single-lane mode. The expected results are a lane-0-only mask with code 0, and an all-zero mask with code 3. The quiet/signalling decision falls on the same lane as the match decision, and lanes on both sides of mantissa bit 22 are judged against select values that take only one of the two NaN kinds.

// File: rtl/vfp_tdc_pkg.sv
package vfp_tdc_pkg;

  localparam int CLASS_W = 12;

  // Positive variant sits one bit above its negative twin.
  localparam int POS_ZERO = 11;
  localparam int POS_NORM = 9;
  localparam int POS_SUB  = 7;
  localparam int POS_INF  = 5;
  localparam int POS_QNAN = 3;
  localparam int POS_SNAN = 1;

  typedef logic [CLASS_W-1:0] class_vec_t;

  typedef enum logic [1:0] {
    CC_ALL  = 2'd0,
    CC_SOME = 2'd1,
    CC_NONE = 2'd3
  } cc_t;

endpackage

// File: rtl/vfp_lane_classify.sv
module vfp_lane_classify
  import vfp_tdc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int ELEM_W = 1 + EXP_W + MAN_W
) (
  input  logic [ELEM_W-1:0] elem,
  output class_vec_t        cls
);

  logic             sgn;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  logic             exp_max;
  logic             exp_zero;
  logic             man_zero;
  int unsigned      base;

  assign sgn      = elem[ELEM_W-1];
  assign expo     = elem[ELEM_W-2 -: EXP_W];
  assign man      = elem[MAN_W-1:0];
  assign exp_max  = &expo;
  assign exp_zero = ~|expo;
  assign man_zero = ~|man;

  always_comb begin
    if (exp_max && man_zero)       base = POS_INF;
    else if (exp_max)              base = man[MAN_W-1] ? POS_QNAN : POS_SNAN;
    else if (exp_zero && man_zero) base = POS_ZERO;
    else if (exp_zero)             base = POS_SUB;
    else                           base = POS_NORM;
  end

  always_comb begin
    cls = '0;
    cls[base - int'(sgn)] = 1'b1;
  end

endmodule

// File: rtl/vfp_cc_encode.sv
module vfp_cc_encode
  import vfp_tdc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] lane_hit,
  input  logic             single_lane,
  output logic [LANES-1:0] lane_keep,
  output cc_t              cc
);

  logic all_hit;
  logic any_hit;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_keep
      if (g == 0) begin : g_first
        assign lane_keep[g] = lane_hit[g];
      end else begin : g_rest
        assign lane_keep[g] = lane_hit[g] & ~single_lane;
      end
    end
  endgenerate

  assign all_hit = single_lane ? lane_hit[0] : &lane_hit;
  assign any_hit = |lane_keep;

  always_comb begin
    if (all_hit)      cc = CC_ALL;
    else if (any_hit) cc = CC_SOME;
    else              cc = CC_NONE;
  end

endmodule

// File: rtl/vfp_class_test.sv
module vfp_class_test
  import vfp_tdc_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int ELEM_W = 1 + EXP_W + MAN_W,
  localparam int VEC_W  = LANES * ELEM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [VEC_W-1:0]   vec_in,
  input  logic [CLASS_W-1:0] class_sel,
  input  logic               single_lane,
  output logic               out_valid,
  output logic [VEC_W-1:0]   mask_out,
  output logic [1:0]         cc_out
);

  class_vec_t       lane_cls [LANES];
  logic [LANES-1:0] lane_hit;
  logic [LANES-1:0] lane_keep;
  logic [VEC_W-1:0] mask_comb;
  cc_t              cc_comb;

  logic [VEC_W-1:0] mask_q, mask_d;
  logic [1:0]       cc_q, cc_d;
  logic             vld_q;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      vfp_lane_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
        .elem (vec_in[g*ELEM_W +: ELEM_W]),
        .cls  (lane_cls[g])
      );
      assign lane_hit[g] = |(lane_cls[g] & class_sel);
      assign mask_comb[g*ELEM_W +: ELEM_W] = {ELEM_W{lane_keep[g]}};

      // R2
      lane_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mask_out[g*ELEM_W +: ELEM_W] == '0 ||
                       mask_out[g*ELEM_W +: ELEM_W] == '1));
    end
  endgenerate

  vfp_cc_encode #(.LANES(LANES)) cc_i (
    .lane_hit    (lane_hit),
    .single_lane (single_lane),
    .lane_keep   (lane_keep),
    .cc          (cc_comb)
  );

  // Next-state with explicit load enable.
  always_comb begin
    mask_d = mask_q;
    cc_d   = cc_q;
    if (in_valid) begin
      mask_d = mask_comb;
      cc_d   = cc_comb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mask_q <= '0;
      cc_q   <= CC_NONE;
    end else begin
      vld_q  <= in_valid;
      mask_q <= mask_d;
      cc_q   <= cc_d;
    end
  end

  assign out_valid = vld_q;
  assign mask_out  = mask_q;
  assign cc_out    = cc_q;

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(mask_out) && $stable(cc_out));

  // R7
  single_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && single_lane |=> mask_out[VEC_W-1:ELEM_W] == '0);

  // R6
  no_cc_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_out != 2'd2);

  // R4
  all_cc_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cc_out == 2'd0 |-> mask_out[ELEM_W-1:0] == '1);

  // R6
  none_cc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cc_out == 2'd3 |-> mask_out == '0);

  // R5
  some_cc_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cc_out == 2'd1 |-> mask_out != '0 && mask_out != '1);

endmodule

// File: tb/vfp_class_test_tb.sv
module vfp_class_test_tb_top;

  localparam int NV = 13;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam logic [31:0] ZER  = 32'h0;

  // Lanes written {lane3, lane2, lane1, lane0}.
  localparam logic [127:0] T_VEC [NV] = '{
    {32'h4049_0FDB, 32'h7F7F_FFFF, 32'h0080_0000, 32'h3F80_0000},
    {32'hBF80_0000, 32'h3F80_0000, 32'h8000_0000, 32'h0000_0000},
    {32'hBF80_0000, 32'h3F80_0000, 32'h8000_0000, 32'h0000_0000},
    {32'hBF80_0000, 32'h3F80_0000, 32'h8000_0000, 32'h0000_0000},
    {32'hFF80_0000, 32'h7F80_0000, 32'h8040_0000, 32'h0000_0001},
    {32'hFFA0_0000, 32'h7F80_0001, 32'hFFC0_0001, 32'h7FC0_0000},
    {32'hFFA0_0000, 32'h7F80_0001, 32'hFFC0_0001, 32'h7FC0_0000},
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h3F80_0000},
    {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000},
    {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h0000_0000},
    {32'h3F80_0000, 32'h7FC0_0000, 32'h0000_0001, 32'h0000_0000},
    {32'hFFA0_0000, 32'h7FC0_0000, 32'h0000_0001, 32'h8000_0000},
    {32'h7FFF_FFFF, 32'h7F80_0000, 32'h7FC0_0000, 32'h7FBF_FFFF}
  };
  localparam logic [11:0] T_SEL [NV] = '{
    12'h200, 12'h800, 12'hC00, 12'h0FF, 12'h0F0, 12'h00A, 12'h005,
    12'h200, 12'h200, 12'h200, 12'h000, 12'hFFF, 12'h002
  };
  localparam logic T_SGL [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0
  };
  localparam logic [127:0] T_MASK [NV] = '{
    {ONES, ONES, ONES, ONES},
    {ZER,  ZER,  ZER,  ONES},
    {ZER,  ZER,  ONES, ONES},
    {ZER,  ZER,  ZER,  ZER },
    {ONES, ONES, ONES, ONES},
    {ZER,  ONES, ZER,  ONES},
    {ONES, ZER,  ONES, ZER },
    {ZER,  ZER,  ZER,  ONES},
    {ZER,  ZER,  ZER,  ONES},
    {ZER,  ZER,  ZER,  ZER },
    {ZER,  ZER,  ZER,  ZER },
    {ONES, ONES, ONES, ONES},
    {ZER,  ZER,  ZER,  ONES}
  };
  localparam logic [1:0] T_CC [NV] = '{
    2'd0, 2'd1, 2'd1, 2'd3, 2'd0, 2'd1, 2'd1,
    2'd0, 2'd0, 2'd3, 2'd3, 2'd0, 2'd1
  };
  localparam string T_REQ [NV] = '{
    "R4", "R5", "R2", "R6", "R1", "R3", "R3",
    "R7", "R7", "R7", "R6", "R1", "R3"
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] vec_in;
  logic [11:0]  class_sel;
  logic         single_lane;
  logic         out_valid;
  logic [127:0] mask_out;
  logic [1:0]   cc_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vfp_class_test dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .vec_in      (vec_in),
    .class_sel   (class_sel),
    .single_lane (single_lane),
    .out_valid   (out_valid),
    .mask_out    (mask_out),
    .cc_out      (cc_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one strobe at a falling edge; the result is registered on the
  // following rising edge and sampled at the next falling edge.
  task automatic apply(input logic [127:0] v, input logic [11:0] s,
                       input logic sg);
    @(negedge clk);
    vec_in      = v;
    class_sel   = s;
    single_lane = sg;
    in_valid    = 1'b1;
    @(negedge clk);
    in_valid    = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    vec_in      = '0;
    class_sel   = '0;
    single_lane = 1'b0;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk("R10", "out_valid", 128'(out_valid), 128'(1'b0));
    chk("R10", "mask",      mask_out,        '0);
    chk("R10", "cc",        128'(cc_out),    128'(2'd3));
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(T_VEC[i], T_SEL[i], T_SGL[i]);
      chk(T_REQ[i], $sformatf("vec%0d mask", i), mask_out, T_MASK[i]);
      chk(T_REQ[i], $sformatf("vec%0d cc", i), 128'(cc_out), 128'(T_CC[i]));
      chk("R8", $sformatf("vec%0d out_valid", i), 128'(out_valid), 128'(1'b1));
    end

    // R8: out_valid drops one cycle after the strobe is removed
    @(negedge clk);
    chk("R8", "out_valid idle", 128'(out_valid), 128'(1'b0));

    // R9: inputs change with no strobe; outputs keep the last result
    vec_in      = {4{32'h3F80_0000}};
    class_sel   = 12'hFFF;
    single_lane = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "mask held", mask_out, T_MASK[NV-1]);
    chk("R9", "cc held", 128'(cc_out), 128'(2'd1));

    // R8: back-to-back strobes each land one cycle later
    @(negedge clk);
    vec_in = {4{32'h0000_0000}}; class_sel = 12'h800; in_valid = 1'b1;
    @(negedge clk);
    chk("R8", "b2b first mask", mask_out, '1);
    chk("R4", "b2b first cc", 128'(cc_out), 128'(2'd0));
    vec_in = {4{32'h0000_0000}}; class_sel = 12'h400;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "b2b second mask", mask_out, '0);
    chk("R6", "b2b second cc", 128'(cc_out), 128'(2'd3));

    // R10: reset mid-run returns to reset values
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", "re-reset cc", 128'(cc_out), 128'(2'd3));
    chk("R10", "re-reset mask", mask_out, '0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule